// File: doc/BRIEF.md
# Instruction Sequencer with Interrupt Entry and Return

This block is the control unit of a small accumulator machine. It walks every instruction through a fixed set of phases. First it reads the opcode at the program counter and waits one cycle for the read data. It then advances the program counter and classifies the opcode. If the opcode needs an operand, it reads the operand word. It then gives the datapath a one-cycle execute strobe, writes the result back if the opcode calls for it, and finally reaches a boundary cycle. Only in that boundary cycle does it look at the interrupt request line.

The block drives a single-port synchronous memory: address, read strobe, write strobe and write data. Read data is valid one cycle after the strobe. The block holds four registers: the program counter, the opcode register, the operand register and an eight-bit condition-code register. The condition-code register takes its value from the ALU's flag byte. A stack-pointer unit keeps a downward-growing stack in the same memory.

Accepting an interrupt pushes the program counter, then the condition codes, and jumps to a fixed service address. A return opcode pops both values in the reverse order and re-opens the block to requests.

Top module: `fx_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the program counter is RESET_PC (0) and the condition codes are 0. The in-service flag and the execute strobe are low, the write strobe is low, and the read strobe is high with the address at the program counter.
- R2: Each instruction starts with a read at the program counter. The opcode is taken from the read data two clock edges after the strobe cycle, so the read has one wait cycle.
- R3: The program counter increases by one for each fetched word: by one for an opcode alone and by two for an opcode with an operand. It changes in the cycle after the opcode read completes.
- R4: The class field is opcode bits [7:4]. Class 1 (immediate ALU), class 2 (store) and class 3 (jump) read an operand word from the program counter, with one wait cycle. Class 4 (return), class 5 (implied ALU) and every other code skip the operand read. Every class not listed here has no effect beyond the program counter advance.
- R5: The execute strobe is high for exactly one cycle per instruction. At the end of that cycle, classes 1 and 5 load the condition-code register from the ALU flag input.
- R6: Class 2 produces a single-cycle write of `wb_data` to the address held in the operand register. No other class writes memory outside interrupt entry.
- R7: Class 3 loads the program counter with the operand.
- R8: The request line is sampled only in the boundary cycle that ends each instruction. A request that has dropped before that cycle has no effect.
- R9: On acceptance, the block writes the program counter to SP-1 and then the condition codes to SP-2, one write per cycle; SP starts at SP_INIT (0xF8). It then loads the program counter with ISR_ADDR (0x80) and sets the in-service flag.
- R10: While the in-service flag is set, requests are not accepted.
- R11: Class 4 reads the condition codes from SP and then the program counter from SP+1, each read with one wait cycle. It raises SP by one per read, clears the in-service flag, and then reaches the boundary cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | W | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid one cycle after the read strobe |
| alu_flags | input | 8 | Flag byte from the ALU |
| wb_data | input | W | Result to store during write-back |
| irq_req | input | 1 | Level-sensitive interrupt request |
| exec_stb | output | 1 | One-cycle execute strobe for the datapath |
| opcode_out | output | W | Current opcode register |
| operand_out | output | W | Current operand register |
| pc_out | output | W | Program counter |
| ccr_out | output | 8 | Condition-code register |
| in_service | output | 1 | Interrupt service in progress |

## Verification
The assertions assume four things about the environment. The memory answers every read exactly one cycle after its strobe. The return opcode is executed only inside a service routine. The stack never grows down into the program or data areas. The request line never changes at a clock edge. The stimulus keeps within these limits: the bench memory has a fixed one-cycle latency, the program places its only return at the end of the service routine, and the request line is driven only on falling edges. The request line is held high across a whole service routine and pulsed so that it drops before a boundary, which exercises the acceptance rules.

// File: rtl/fx_pkg.sv
package fx_pkg;

    localparam int FLAG_W = 8;
    localparam int CLS_W  = 4;

    localparam logic [CLS_W-1:0] CLS_ALU_IMM = 4'h1;
    localparam logic [CLS_W-1:0] CLS_STORE   = 4'h2;
    localparam logic [CLS_W-1:0] CLS_JUMP    = 4'h3;
    localparam logic [CLS_W-1:0] CLS_RETURN  = 4'h4;
    localparam logic [CLS_W-1:0] CLS_ALU_IMP = 4'h5;

    typedef enum logic [3:0] {
        S_FETCH, S_FETCH_W, S_INCR, S_DECODE,
        S_OPND, S_OPND_W, S_EXEC, S_WB, S_CHECK,
        S_PUSH_PC, S_PUSH_CC,
        S_POP_CC, S_POP_CC_W, S_POP_PC, S_POP_PC_W
    } fx_state_e;

    typedef struct packed {
        logic need_opnd;
        logic do_wb;
        logic upd_flags;
        logic is_jump;
        logic is_ret;
    } fx_dec_t;

    function automatic fx_dec_t decode_class(input logic [CLS_W-1:0] cls);
        fx_dec_t d;
        d = '0;
        unique case (cls)
            CLS_ALU_IMM: begin d.need_opnd = 1'b1; d.upd_flags = 1'b1; end
            CLS_STORE:   begin d.need_opnd = 1'b1; d.do_wb = 1'b1; end
            CLS_JUMP:    begin d.need_opnd = 1'b1; d.is_jump = 1'b1; end
            CLS_RETURN:  d.is_ret = 1'b1;
            CLS_ALU_IMP: d.upd_flags = 1'b1;
            default:     d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fx_decode.sv
module fx_decode
    import fx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opcode,
    output fx_dec_t      dec
);
    localparam int CLS_LSB = W - CLS_W;

    logic [CLS_W-1:0] cls;
    assign cls = opcode[W-1:CLS_LSB];
    assign dec = decode_class(cls);
endmodule

// File: rtl/fx_stack.sv
module fx_stack #(
    parameter int          W       = 8,
    parameter logic [W-1:0] SP_INIT = 8'hF8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    output logic [W-1:0] sp,
    output logic [W-1:0] sp_down
);
    localparam logic [W-1:0] ONE = W'(1);

    assign sp_down = sp - ONE;

    always_ff @(posedge clk) begin
        if (rst)       sp <= SP_INIT;
        else if (push) sp <= sp_down;
        else if (pop)  sp <= sp + ONE;
    end

    assert_single_op_R9: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
endmodule

// File: rtl/fx_ctrl.sv
module fx_ctrl
    import fx_pkg::*;
#(
    parameter int           W        = 8,
    parameter logic [W-1:0] ISR_ADDR = 8'h80,
    parameter logic [W-1:0] SP_INIT  = 8'hF8,
    parameter logic [W-1:0] RESET_PC = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    output logic [W-1:0]      mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [W-1:0]      mem_wdata,
    input  logic [W-1:0]      mem_rdata,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic [W-1:0]      wb_data,
    input  logic              irq_req,
    output logic              exec_stb,
    output logic [W-1:0]      opcode_out,
    output logic [W-1:0]      operand_out,
    output logic [W-1:0]      pc_out,
    output logic [FLAG_W-1:0] ccr_out,
    output logic              in_service
);
    localparam logic [W-1:0] ONE = W'(1);

    fx_state_e         state;
    logic [W-1:0]      pc, ir, opnd;
    logic [FLAG_W-1:0] ccr;
    logic              in_svc;
    fx_dec_t           dec_now, dec_q;
    logic [W-1:0]      sp, sp_down;
    logic              sp_push, sp_pop;

    fx_decode #(.W(W)) u_decode (
        .opcode (ir),
        .dec    (dec_now)
    );

    assign sp_push = (state == S_PUSH_PC) || (state == S_PUSH_CC);
    assign sp_pop  = (state == S_POP_CC_W) || (state == S_POP_PC_W);

    fx_stack #(.W(W), .SP_INIT(SP_INIT)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .push    (sp_push),
        .pop     (sp_pop),
        .sp      (sp),
        .sp_down (sp_down)
    );

    // Memory strobes and address selection per phase
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = pc;
        mem_wdata = '0;
        exec_stb  = 1'b0;
        unique case (state)
            S_FETCH, S_OPND: mem_rd = 1'b1;
            S_EXEC:          exec_stb = 1'b1;
            S_WB: begin
                mem_wr    = 1'b1;
                mem_addr  = opnd;
                mem_wdata = wb_data;
            end
            S_PUSH_PC: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_down;
                mem_wdata = pc;
            end
            S_PUSH_CC: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_down;
                mem_wdata = W'(ccr);
            end
            S_POP_CC, S_POP_PC: begin
                mem_rd   = 1'b1;
                mem_addr = sp;
            end
            default: ;
        endcase
    end

    // Phase sequencer and architectural registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_FETCH;
            pc     <= RESET_PC;
            ir     <= '0;
            opnd   <= '0;
            ccr    <= '0;
            in_svc <= 1'b0;
            dec_q  <= '0;
        end else begin
            unique case (state)
                S_FETCH:   state <= S_FETCH_W;
                S_FETCH_W: begin
                    ir    <= mem_rdata;
                    state <= S_INCR;
                end
                S_INCR: begin
                    pc    <= pc + ONE;
                    state <= S_DECODE;
                end
                S_DECODE: begin
                    dec_q <= dec_now;
                    state <= dec_now.need_opnd ? S_OPND : S_EXEC;
                end
                S_OPND:   state <= S_OPND_W;
                S_OPND_W: begin
                    opnd  <= mem_rdata;
                    pc    <= pc + ONE;
                    state <= S_EXEC;
                end
                S_EXEC: begin
                    if (dec_q.upd_flags) ccr <= alu_flags;
                    if (dec_q.is_jump)   pc  <= opnd;
                    if (dec_q.is_ret)      state <= S_POP_CC;
                    else if (dec_q.do_wb)  state <= S_WB;
                    else                   state <= S_CHECK;
                end
                S_WB:    state <= S_CHECK;
                S_CHECK: state <= (irq_req && !in_svc) ? S_PUSH_PC : S_FETCH;
                S_PUSH_PC: state <= S_PUSH_CC;
                S_PUSH_CC: begin
                    pc     <= ISR_ADDR;
                    in_svc <= 1'b1;
                    state  <= S_FETCH;
                end
                S_POP_CC:   state <= S_POP_CC_W;
                S_POP_CC_W: begin
                    ccr   <= mem_rdata[FLAG_W-1:0];
                    state <= S_POP_PC;
                end
                S_POP_PC:   state <= S_POP_PC_W;
                S_POP_PC_W: begin
                    pc     <= mem_rdata;
                    in_svc <= 1'b0;
                    state  <= S_CHECK;
                end
                default: state <= S_FETCH;
            endcase
        end
    end

    assign opcode_out  = ir;
    assign operand_out = opnd;
    assign pc_out      = pc;
    assign ccr_out     = ccr;
    assign in_service  = in_svc;

    assert_exec_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        exec_stb |=> !exec_stb);

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE) |-> (pc == $past(pc) + ONE));

    assert_entry_vector_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(in_svc) |-> (pc == ISR_ADDR && sp == $past(sp) - ONE));

    assert_blocked_in_service_R10: assert property (@(posedge clk) disable iff (rst)
        (state == S_CHECK && in_svc) |=> (state == S_FETCH));

    assert_return_pop_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(in_svc) |-> (sp == $past(sp) + ONE && state == S_CHECK));
endmodule

// File: tb/test_fx_ctrl.sv
module test_fx_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_INSTR    = 80;
    localparam logic [7:0] ISR = 8'h80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, wb_data, opcode_out, operand_out, pc_out;
    logic [7:0] alu_flags, ccr_out;
    logic       mem_rd, mem_wr, irq_req, exec_stb, in_service;

    logic [7:0] mem     [256];
    logic [7:0] ref_mem [256];

    int n_cmp = 0;
    int n_bad = 0;
    int entries = 0;
    bit live = 1'b0;

    logic       e_rd, e_wr, e_ex, e_svc;
    logic [7:0] e_addr, e_wd, e_pc, e_ccr;
    string      e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    fx_ctrl i_fx_ctrl (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .alu_flags(alu_flags),
        .wb_data(wb_data), .irq_req(irq_req), .exec_stb(exec_stb),
        .opcode_out(opcode_out), .operand_out(operand_out), .pc_out(pc_out),
        .ccr_out(ccr_out), .in_service(in_service)
    );

    // Stand-in datapath: flags and result derived from the visible registers
    assign alu_flags = opcode_out ^ operand_out;
    assign wb_data   = operand_out ^ 8'h5A;

    // Memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            chk(mem_rd === e_rd, e_tag, "mem_rd", mem_rd, e_rd);
            chk(mem_wr === e_wr, e_tag, "mem_wr", mem_wr, e_wr);
            chk(exec_stb === e_ex, e_tag, "exec_stb", exec_stb, e_ex);
            chk(pc_out === e_pc, e_tag, "pc", pc_out, e_pc);
            chk(ccr_out === e_ccr, e_tag, "ccr", ccr_out, e_ccr);
            chk(in_service === e_svc, e_tag, "in_service", in_service, e_svc);
            if (e_rd || e_wr) chk(mem_addr === e_addr, e_tag, "mem_addr", mem_addr, e_addr);
            if (e_wr) chk(mem_wdata === e_wd, e_tag, "mem_wdata", mem_wdata, e_wd);
            if ($rose(in_service)) entries++;
        end
    end

    // Reference model state
    logic [7:0] m_pc = 8'h00, m_ir = 8'h00, m_op = 8'h00, m_ccr = 8'h00, m_sp = 8'hF8;
    bit         m_svc = 1'b0;

    task automatic cyc(input bit rd, input bit wr, input logic [7:0] a, input logic [7:0] wd,
                       input bit ex, input string tag, output bit irq_s);
        e_rd = rd; e_wr = wr; e_addr = a; e_wd = wd; e_ex = ex; e_tag = tag;
        e_pc = m_pc; e_ccr = m_ccr; e_svc = m_svc;
        @(posedge clk);
        irq_s = irq_req;
        #1;
    endtask

    task automatic load_program;
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; ref_mem[i] = 8'h00; end
        // main: immediate ALU, implied ALU, no-op, store, jump into loop
        ref_mem[8'h00] = 8'h12; ref_mem[8'h01] = 8'h34;
        ref_mem[8'h02] = 8'h50;
        ref_mem[8'h03] = 8'h00;
        ref_mem[8'h04] = 8'h25; ref_mem[8'h05] = 8'h40;
        ref_mem[8'h06] = 8'h30; ref_mem[8'h07] = 8'h0A;
        // loop: unlisted class, immediate ALU, implied ALU, jump back
        ref_mem[8'h0A] = 8'h9C;
        ref_mem[8'h0B] = 8'h13; ref_mem[8'h0C] = 8'h07;
        ref_mem[8'h0D] = 8'h50;
        ref_mem[8'h0E] = 8'h30; ref_mem[8'h0F] = 8'h0A;
        // service routine: flag change, store, return
        ref_mem[8'h80] = 8'h55;
        ref_mem[8'h81] = 8'h26; ref_mem[8'h82] = 8'h41;
        ref_mem[8'h83] = 8'h40;
        for (int i = 0; i < 256; i++) mem[i] = ref_mem[i];
    endtask

    // Reset, then behavioural reference model stepping one cycle at a time
    initial begin
        bit s;
        logic [3:0] cls;
        logic [7:0] old_pc;
        bit first = 1'b1;
        load_program();
        repeat (2) @(posedge clk);
        #1;
        chk(pc_out === 8'h00, "R1", "reset pc", pc_out, 0);
        chk(ccr_out === 8'h00, "R1", "reset ccr", ccr_out, 0);
        chk(in_service === 1'b0, "R1", "reset in_service", in_service, 0);
        chk(mem_wr === 1'b0 && exec_stb === 1'b0, "R1", "reset strobes", {mem_wr, exec_stb}, 0);
        @(posedge clk);
        rst <= 1'b0;
        live = 1'b1;
        for (int n = 0; n < N_INSTR; n++) begin
            cyc(1, 0, m_pc, 0, 0, first ? "R1" : "R2", s);
            first = 1'b0;
            cyc(0, 0, 0, 0, 0, "R2", s);
            m_ir = ref_mem[m_pc];
            chk(opcode_out === m_ir, "R2", "opcode", opcode_out, m_ir);
            old_pc = m_pc;
            cyc(0, 0, 0, 0, 0, "R3", s);
            m_pc = m_pc + 8'd1;
            chk(pc_out === old_pc + 8'd1, "R3", "pc step", pc_out, old_pc + 8'd1);
            cls = m_ir[7:4];
            cyc(0, 0, 0, 0, 0, "R4", s);
            if (cls == 4'h1 || cls == 4'h2 || cls == 4'h3) begin
                cyc(1, 0, m_pc, 0, 0, "R4", s);
                cyc(0, 0, 0, 0, 0, "R4", s);
                m_op = ref_mem[m_pc];
                m_pc = m_pc + 8'd1;
            end
            cyc(0, 0, 0, 0, 1, "R5", s);
            if (cls == 4'h1 || cls == 4'h5) m_ccr = m_ir ^ m_op;
            if (cls == 4'h3) begin
                m_pc = m_op;
                chk(pc_out === m_op, "R7", "jump target", pc_out, m_op);
            end
            if (cls == 4'h4) begin
                cyc(1, 0, m_sp, 0, 0, "R11", s);
                cyc(0, 0, 0, 0, 0, "R11", s);
                m_ccr = ref_mem[m_sp];
                m_sp = m_sp + 8'd1;
                cyc(1, 0, m_sp, 0, 0, "R11", s);
                cyc(0, 0, 0, 0, 0, "R11", s);
                m_pc = ref_mem[m_sp];
                m_sp = m_sp + 8'd1;
                m_svc = 1'b0;
            end else if (cls == 4'h2) begin
                cyc(0, 1, m_op, m_op ^ 8'h5A, 0, "R6", s);
                ref_mem[m_op] = m_op ^ 8'h5A;
            end
            cyc(0, 0, 0, 0, 0, m_svc ? "R10" : "R8", s);
            if (s && !m_svc) begin
                cyc(0, 1, m_sp - 8'd1, m_pc, 0, "R9", s);
                m_sp = m_sp - 8'd1;
                ref_mem[m_sp] = m_pc;
                cyc(0, 1, m_sp - 8'd1, m_ccr, 0, "R9", s);
                m_sp = m_sp - 8'd1;
                ref_mem[m_sp] = m_ccr;
                m_pc = ISR;
                m_svc = 1'b1;
            end
        end
        live = 1'b0;
        @(negedge clk);
        chk(mem[8'h40] === 8'h1A, "R6", "store in main", mem[8'h40], 8'h1A);
        chk(mem[8'h41] === 8'h1B, "R6", "store in service", mem[8'h41], 8'h1B);
        chk(mem[8'hF7] === ref_mem[8'hF7], "R9", "stacked pc", mem[8'hF7], ref_mem[8'hF7]);
        chk(mem[8'hF6] === ref_mem[8'hF6], "R9", "stacked ccr", mem[8'hF6], ref_mem[8'hF6]);
        chk(entries == 2, "R10", "service entries", entries, 2);
        chk(in_service === 1'b0, "R11", "final in_service", in_service, 0);
        finish_run();
    end

    // Interrupt stimulus, changed only on falling edges
    initial begin
        irq_req = 1'b0;
        wait (live);
        repeat (12) @(negedge clk);
        // R8: short pulse that is gone before the boundary cycle
        @(negedge clk iff exec_stb);
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        repeat (20) @(negedge clk);
        // R10: held high through a whole service routine, taken again after return
        irq_req = 1'b1;
        @(negedge clk iff in_service);
        @(negedge clk iff !in_service);
        @(negedge clk iff in_service);
        irq_req = 1'b0;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end
endmodule